// File: doc/BRIEF.md
# Serial Register File for a Four-Digit Display Controller

This block is the host-facing register file of a small display controller. A host drives a four-wire serial link: an active-low select, a serial clock, a data input and a data output. Every transfer is a 16-bit frame sent most-significant bit first. The top bit asks for a read when it is 1. The next seven bits select a register, and the low byte carries write data, or filler on a read. The block samples the three serial inputs on its own system clock through two-stage synchronizers. It acts on a frame only when the select returns high.

The storage holds six control bytes: two brightness bytes, a digit-count limit, a mode byte, a glyph-access byte and a self-test byte. It also holds one data byte per digit in each of two planes. A group of alias addresses loads a digit's byte into both planes at once. Reads are deferred by one frame. At the end of a read frame the low byte of the shift register is replaced by the register contents. The host then clocks out the whole shift register during its next frame, and that frame may be a harmless no-op.

The display scan, glyph lookup and brightness modulation sit outside this block. They use the register contents on the output buses.

Top module: `seg_serial_regfile`

## Requirements
- R1: A frame is accepted only if exactly 16 bits were clocked in while `csn_i` was low, MSB first. Bit 15 = read flag (1 = read), bits 14..8 = address, bits 7..0 = data.
- R2: After reset every register output and `sdo_o` are 0.
- R3: A write updates a control output: address 0x01 → `intensity_lo_o`, 0x02 → `intensity_hi_o`, 0x03 → `scan_limit_o`, 0x04 → `config_o`, 0x05 → `font_sel_o`, 0x07 → `test_o`.
- R4: A write to 0x20+d sets byte d (bits 8d+7..8d) of `plane0_o`, and a write to 0x40+d sets byte d of `plane1_o`, for d = 0..3.
- R5: A write to 0x60+d sets byte d of both planes to the same value. A read of 0x60+d returns 0x00.
- R6: When `csn_i` rises after an accepted read, bits 7..0 of the shift register take the addressed register's value. The next frame outputs that byte on `sdo_o` as its bits 8..15.
- R7: `sdo_o` shows the shift register MSB, and the register shifts left on each serial clock rise. A frame therefore outputs the previous frame's 16 bits in order: after a write, its command byte and then its data byte.
- R8: A frame of any other length changes no register and loads no read data. Its bits still pass through the shift register.
- R9: Writes to 0x00, 0x06 and every unmapped address change nothing, and reads of them return 0x00.
- R10: A write takes effect in one system-clock cycle after the synchronized select rises. Register outputs do not change before that rise.
- R11: `sdo_o` holds steady while `csn_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, data sampled on its rising edge |
| csn_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, shift register MSB |
| intensity_lo_o | output | 8 | Brightness byte, address 0x01 |
| intensity_hi_o | output | 8 | Brightness byte, address 0x02 |
| scan_limit_o | output | 8 | Digit-count limit, address 0x03 |
| config_o | output | 8 | Mode byte, address 0x04 |
| font_sel_o | output | 8 | Glyph-access byte, address 0x05 |
| test_o | output | 8 | Self-test byte, address 0x07 |
| plane0_o | output | 32 | Plane-0 bytes, digit d at bits 8d+7..8d |
| plane1_o | output | 32 | Plane-1 bytes, digit d at bits 8d+7..8d |

## Verification
Every one of the 128 addresses is written with a byte derived from the address. Each write is followed by a comparison of all register outputs, so a misdecoded or aliased address shows up as a stray change. The plane-0 digits are then rewritten with distinct bytes, which separates the two planes after the dual-plane aliases had made them equal. A read sweep over all 128 addresses compares every next-frame output word, which tells the echoed command byte apart from loaded read data and from the zero returned by alias, reserved and unmapped addresses. Frames of 15 and 17 bits check that short and long frames leave the storage alone while still shifting.

// File: rtl/seg_regfile_pkg.sv
package seg_regfile_pkg;
  localparam int CTRL_SLOTS = 8;
  localparam logic [2:0] SLOT_NOP  = 3'd0;
  localparam logic [2:0] SLOT_RSVD = 3'd6;
  localparam logic [1:0] BANK_CTRL = 2'b00;
  localparam logic [1:0] BANK_P0   = 2'b01;
  localparam logic [1:0] BANK_P1   = 2'b10;
  localparam logic [1:0] BANK_BOTH = 2'b11;

  function automatic logic slot_used(input logic [2:0] s);
    return (s != SLOT_NOP) && (s != SLOT_RSVD);
  endfunction
endpackage

// File: rtl/seg_sync.sv
module seg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/seg_frame_shifter.sv
module seg_frame_shifter #(
  parameter int FRAME_BITS = 16,
  parameter int DW         = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sck_i,
  input  logic                  csn_i,
  input  logic                  sdi_i,
  input  logic [DW-1:0]         rd_data_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  wr_o
);
  localparam int CW = $clog2(FRAME_BITS) + 1;
  localparam logic [CW-1:0] CNT_MAX  = '1;
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);

  logic          sck_q, csn_q;
  logic [CW-1:0] cnt_q;
  logic          sck_rise, csn_rise, csn_fall;

  assign sck_rise = sck_i & ~sck_q;
  assign csn_rise = csn_i & ~csn_q;
  assign csn_fall = ~csn_i & csn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      csn_q   <= 1'b1;
      cnt_q   <= '0;
      frame_o <= '0;
      wr_o    <= 1'b0;
    end else begin
      sck_q <= sck_i;
      csn_q <= csn_i;
      wr_o  <= 1'b0;
      if (csn_fall) begin
        cnt_q <= '0;
      end else if (sck_rise && !csn_i) begin
        frame_o <= {frame_o[FRAME_BITS-2:0], sdi_i};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end else if (csn_rise && cnt_q == CNT_FULL) begin
        // read: park data in the low byte for the next frame
        if (frame_o[FRAME_BITS-1]) frame_o[DW-1:0] <= rd_data_i;
        else                       wr_o <= 1'b1;
      end
    end
  end

  assert_wr_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_i && csn_q) |=> $stable(frame_o));
endmodule

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_regfile_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int DW         = 8,
  parameter int AW         = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [AW-1:0]            wr_addr_i,
  input  logic [DW-1:0]            wr_data_i,
  input  logic [AW-1:0]            rd_addr_i,
  output logic [DW-1:0]            rd_data_o,
  output logic [CTRL_SLOTS*DW-1:0] ctrl_o,
  output logic [NUM_DIGITS*DW-1:0] plane0_o,
  output logic [NUM_DIGITS*DW-1:0] plane1_o
);
  localparam int DIGW = AW - 2;

  logic [1:0]      wr_bank, rd_bank;
  logic [DIGW-1:0] wr_dig, rd_dig;
  logic            ctrl_hit, wr_known;

  assign wr_bank  = wr_addr_i[AW-1 -: 2];
  assign rd_bank  = rd_addr_i[AW-1 -: 2];
  assign wr_dig   = wr_addr_i[DIGW-1:0];
  assign rd_dig   = rd_addr_i[DIGW-1:0];
  assign ctrl_hit = wr_i && wr_bank == BANK_CTRL && wr_addr_i[DIGW-1:3] == '0;

  for (genvar s = 0; s < CTRL_SLOTS; s++) begin : g_ctrl
    if (!slot_used(3'(s))) begin : g_none
      assign ctrl_o[s*DW +: DW] = '0;
    end else begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  q <= '0;
        else if (ctrl_hit && wr_addr_i[2:0] == 3'(s)) q <= wr_data_i;
      end
      assign ctrl_o[s*DW +: DW] = q;
    end
  end

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_dig
    logic [DW-1:0] p0_q, p1_q;
    logic          we0, we1;
    assign we0 = wr_i && wr_dig == DIGW'(d) && (wr_bank == BANK_P0 || wr_bank == BANK_BOTH);
    assign we1 = wr_i && wr_dig == DIGW'(d) && (wr_bank == BANK_P1 || wr_bank == BANK_BOTH);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        p0_q <= '0;
        p1_q <= '0;
      end else begin
        if (we0) p0_q <= wr_data_i;
        if (we1) p1_q <= wr_data_i;
      end
    end
    assign plane0_o[d*DW +: DW] = p0_q;
    assign plane1_o[d*DW +: DW] = p1_q;

    assert_dual_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && wr_bank == BANK_BOTH && wr_dig == DIGW'(d))
      |=> (p0_q == p1_q && p0_q == $past(wr_data_i)));
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_bank)
      BANK_CTRL: if (rd_addr_i[DIGW-1:3] == '0) rd_data_o = ctrl_o[int'(rd_addr_i[2:0])*DW +: DW];
      BANK_P0:   if (32'(rd_dig) < NUM_DIGITS) rd_data_o = plane0_o[int'(rd_dig)*DW +: DW];
      BANK_P1:   if (32'(rd_dig) < NUM_DIGITS) rd_data_o = plane1_o[int'(rd_dig)*DW +: DW];
      default:   rd_data_o = '0;
    endcase
  end

  assign wr_known = (wr_bank == BANK_CTRL)
                  ? (wr_addr_i[DIGW-1:3] == '0 && slot_used(wr_addr_i[2:0]))
                  : (32'(wr_dig) < NUM_DIGITS);

  assert_ignored_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_known) |=> ($stable(ctrl_o) && $stable(plane0_o) && $stable(plane1_o)));

  assert_hold_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(ctrl_o) && $stable(plane0_o) && $stable(plane1_o)));
endmodule

// File: rtl/seg_serial_regfile.sv
module seg_serial_regfile
  import seg_regfile_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int DW         = 8,
  parameter int AW         = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sck_i,
  input  logic                     csn_i,
  input  logic                     sdi_i,
  output logic                     sdo_o,
  output logic [DW-1:0]            intensity_lo_o,
  output logic [DW-1:0]            intensity_hi_o,
  output logic [DW-1:0]            scan_limit_o,
  output logic [DW-1:0]            config_o,
  output logic [DW-1:0]            font_sel_o,
  output logic [DW-1:0]            test_o,
  output logic [NUM_DIGITS*DW-1:0] plane0_o,
  output logic [NUM_DIGITS*DW-1:0] plane1_o
);
  localparam int FRAME_BITS = 1 + AW + DW;

  logic [2:0]              sync_q;
  logic                    sck_s, csn_s, sdi_s;
  logic [FRAME_BITS-1:0]   frame;
  logic                    wr;
  logic [DW-1:0]           rd_data;
  logic [CTRL_SLOTS*DW-1:0] ctrl;

  seg_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, csn_i, sdi_i}),
    .q_o   (sync_q)
  );
  assign {sck_s, csn_s, sdi_s} = sync_q;

  seg_frame_shifter #(.FRAME_BITS(FRAME_BITS), .DW(DW)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_i    (sck_s),
    .csn_i    (csn_s),
    .sdi_i    (sdi_s),
    .rd_data_i(rd_data),
    .frame_o  (frame),
    .wr_o     (wr)
  );

  seg_regfile #(.NUM_DIGITS(NUM_DIGITS), .DW(DW), .AW(AW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .wr_addr_i(frame[DW +: AW]),
    .wr_data_i(frame[DW-1:0]),
    .rd_addr_i(frame[DW +: AW]),
    .rd_data_o(rd_data),
    .ctrl_o   (ctrl),
    .plane0_o (plane0_o),
    .plane1_o (plane1_o)
  );

  assign sdo_o          = frame[FRAME_BITS-1];
  assign intensity_lo_o = ctrl[1*DW +: DW];
  assign intensity_hi_o = ctrl[2*DW +: DW];
  assign scan_limit_o   = ctrl[3*DW +: DW];
  assign config_o       = ctrl[4*DW +: DW];
  assign font_sel_o     = ctrl[5*DW +: DW];
  assign test_o         = ctrl[7*DW +: DW];

  assert_write_between_frames_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |-> csn_s);

  assert_sdo_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_s && $past(csn_s)) |=> $stable(sdo_o));
endmodule

// File: tb/seg_serial_regfile_test.sv
module seg_serial_regfile_test;
  localparam int ND = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic sdo;
  logic [7:0] ilo, ihi, slim, cfg, fsel, tst;
  logic [31:0] pl0, pl1;

  always #5 clk = ~clk;

  seg_serial_regfile uut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .csn_i(csn), .sdi_i(sdi), .sdo_o(sdo),
    .intensity_lo_o(ilo), .intensity_hi_o(ihi), .scan_limit_o(slim), .config_o(cfg),
    .font_sel_o(fsel), .test_o(tst), .plane0_o(pl0), .plane1_o(pl1)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_ctrl [8];
  logic [7:0] m_p0 [ND];
  logic [7:0] m_p1 [ND];
  logic [15:0] m_sh = '0;
  string m_tag = "R2";

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit ctrl_used(input int a);
    return (a >= 1 && a <= 5) || a == 7;
  endfunction

  function automatic logic [7:0] rd_model(input int a);
    if (ctrl_used(a)) return m_ctrl[a];
    if ((a >> 5) == 1 && (a & 31) < ND) return m_p0[a & 31];
    if ((a >> 5) == 2 && (a & 31) < ND) return m_p1[a & 31];
    return 8'h00;
  endfunction

  function automatic string addr_tag(input int a);
    if (ctrl_used(a)) return "R3";
    if (((a >> 5) == 1 || (a >> 5) == 2) && (a & 31) < ND) return "R4";
    if ((a >> 5) == 3 && (a & 31) < ND) return "R5";
    return "R9";
  endfunction

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check_ports(input string req);
    logic [63:0] ep, ap;
    check(req, {16'h0, tst, fsel, cfg, slim, ihi, ilo},
          {16'h0, m_ctrl[7], m_ctrl[5], m_ctrl[4], m_ctrl[3], m_ctrl[2], m_ctrl[1]});
    ep = '0;
    for (int d = 0; d < ND; d++) begin
      ep[d*8 +: 8]      = m_p0[d];
      ep[32 + d*8 +: 8] = m_p1[d];
    end
    ap = {pl1, pl0};
    check(req, ap, ep);
  endtask

  // one frame of nbits; bits past 16 are zero
  task automatic send(input logic [15:0] cmd, input int nbits);
    logic [15:0] got;
    logic b;
    int a;
    got = '0;
    a = int'(cmd[14:8]);
    csn = 1'b0;
    wait_clk(6);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? cmd[15-i] : 1'b0;
      sck = 1'b0;
      wait_clk(6);
      if (i < 16) got[15-i] = sdo;
      sck = 1'b1;
      wait_clk(6);
    end
    sck = 1'b0;
    wait_clk(6);
    if (nbits == 16) check(m_tag, 64'(got), 64'(m_sh));
    check_ports("R10");  // nothing applied before select rises
    csn = 1'b1;
    wait_clk(10);
    for (int i = 0; i < nbits; i++) begin
      b = (i < 16) ? cmd[15-i] : 1'b0;
      m_sh = {m_sh[14:0], b};
    end
    if (nbits != 16) begin
      m_tag = "R8";
    end else if (cmd[15]) begin
      m_sh[7:0] = rd_model(a);
      m_tag = (addr_tag(a) == "R5" || addr_tag(a) == "R9") ? addr_tag(a) : "R6";
    end else begin
      if (ctrl_used(a)) m_ctrl[a] = cmd[7:0];
      if (((a >> 5) == 1 || (a >> 5) == 3) && (a & 31) < ND) m_p0[a & 31] = cmd[7:0];
      if (((a >> 5) == 2 || (a >> 5) == 3) && (a & 31) < ND) m_p1[a & 31] = cmd[7:0];
      m_tag = "R7";
    end
    check("R11", 64'(sdo), 64'(m_sh[15]));
    wait_clk(4);
    check("R11", 64'(sdo), 64'(m_sh[15]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_ctrl[i] = '0;
    for (int d = 0; d < ND; d++) begin
      m_p0[d] = '0;
      m_p1[d] = '0;
    end
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(5);
    check_ports("R2");
    check("R2", 64'(sdo), 64'h0);

    // write sweep over every address
    for (int a = 0; a < 128; a++) begin
      send({1'b0, 7'(a), pat(a)}, 16);
      check_ports({"R1 ", addr_tag(a)});
    end
    // separate the planes again
    for (int d = 0; d < ND; d++) begin
      send({1'b0, 7'(8'h20 + d), 8'(8'hC0 + d)}, 16);
      check_ports("R4");
    end
    // read sweep; each result checked in the following frame
    for (int a = 0; a < 128; a++) send({1'b1, 7'(a), 8'hFF}, 16);
    send(16'h8000, 16);

    // wrong-length frames
    send({1'b0, 7'h21, 8'hAA}, 15);
    check_ports("R8");
    send({1'b0, 7'h03, 8'h55}, 17);
    check_ports("R8");
    send({1'b1, 7'h22, 8'h00}, 15);
    send(16'h8000, 16);
    send(16'h8000, 16);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule